// File: doc/BRIEF.md
# Flash Command Sequencer with Indexed Opcode Table

This block issues serial-flash commands that software has built from a small table of opcodes. Software fills an eight-entry opcode table, held as two 32-bit words. It also fills a companion register that holds two prefix opcodes and a 2-bit kind field for each table entry. The kind field says whether the entry reads or writes and whether an address phase follows the opcode. A write to the control word starts a command. The control word selects a table entry, the data byte count, whether a data phase is present, which prefix to use, and whether the command is atomic.

Each step of a command is handed to an external serial shifter as one chip-select frame, through a valid/done handshake. A plain command is a single frame. When the data phase is disabled, only the opcode (and the address, if the kind has one) goes out, which is how erase commands are sent. An atomic command runs as three stages:
- a prefix frame, typically write-enable;
- the main frame;
- status-read frames, repeated until the flash reports that it is no longer busy.

A lock input freezes the opcode table and the prefix/kind register until reset.

Top module: `flash_swseq`

## Requirements
- R1: Table entry i is byte i mod 4 (bits 8k+7:8k, k = i mod 4) of the low table word for i < 4, and of the high table word for i >= 4. The selected byte is presented on `sh_opcode` for the main frame.
- R2: The prefix/kind register holds prefix A in bits 7:0 and prefix B in bits 15:8. The kind of entry i is in bits 17+2i:16+2i. Kind codes are: 0 read, no address; 1 write, no address; 2 read with address; 3 write with address. Kind bit 1 drives `sh_addr_en` and kind bit 0 drives `sh_write` on the main frame. All three configuration registers read back as written.
- R3: The control/status word (select 0) has these fields: go at bit 9, atomic at bit 10, prefix select at bit 11, entry index at bits 14:12, byte count minus one at bits 21:16, data enable at bit 22. A write with go set while idle raises `sh_valid` in the following cycle.
- R4: The main frame drives `sh_data_en` from the data enable bit and `sh_data_cnt` from the count field. With data enable clear, no data phase is requested.
- R5: Status bit 0 (in progress) is high from the cycle after go until the sequence ends. When the sequence ends, bit 2 (done) is set. Bits 2, 3 and 4 are cleared by writing 1, and the read-back also shows the latched control fields.
- R6: An atomic command first sends a prefix-only frame with prefix A, or with prefix B when prefix select is 1. It then sends the main frame as a separate frame.
- R7: After an atomic main frame, the block sends status-read frames: opcode 0x05, no address, read, data enabled, count 0. It keeps sending them until the byte returned with `sh_done` has bit 0 clear, and then sets done.
- R8: A go with atomic set on a read-kind entry sets the error bit (bit 3), sends no frame and leaves in-progress low.
- R9: After a `lock_req` pulse, status bit 15 stays high until reset. Writes to the table words and to the prefix/kind register are then ignored. Commands can still be started.
- R10: A go written while a command is in progress is ignored: the running sequence and its latched fields are unchanged.
- R11: A `sh_done` accompanied by `sh_err` sets the access-error bit (bit 4) and done, and ends the sequence with no further frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control/status, 1 prefix/kind, 2 table low, 3 table high |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | 32 | Read data (combinational) |
| lock_req | input | 1 | Sets the configuration lock |
| sh_valid | output | 1 | Frame request to the shifter, held until sh_done |
| sh_opcode | output | 8 | Opcode of the frame |
| sh_addr_en | output | 1 | Frame carries an address phase |
| sh_write | output | 1 | Data phase direction, 1 = to flash |
| sh_data_en | output | 1 | Frame has a data phase |
| sh_data_cnt | output | 6 | Data bytes minus one |
| sh_done | input | 1 | Shifter finished the frame (one-cycle pulse) |
| sh_err | input | 1 | Frame failed, qualified by sh_done |
| sh_rdata | input | 8 | Last byte read in the frame, qualified by sh_done |

## Verification
A wrong sequencer state shows up first on the shifter port. A missing or extra frame, a wrong opcode or a wrong kind bit is visible at the first `sh_valid` after go, which is the cycle after the control write. A polling loop that ends early or never ends shows in the number of status-read frames, and in the done bit at the end of the sequence. Corrupted configuration or latched fields show up in the register read-back as soon as the next read. A lock that fails to hold shows up as a changed table word on the read that follows the blocked write.

// File: rtl/flash_swseq.sv
module flash_swseq #(
  parameter logic [7:0] POLL_OP  = 8'h05,
  parameter int         BUSY_BIT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        lock_req,
  output logic        sh_valid,
  output logic [7:0]  sh_opcode,
  output logic        sh_addr_en,
  output logic        sh_write,
  output logic        sh_data_en,
  output logic [5:0]  sh_data_cnt,
  input  logic        sh_done,
  input  logic        sh_err,
  input  logic [7:0]  sh_rdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_MAIN, ST_POLL} st_t;

  st_t         st;
  logic [31:0] menu_lo, menu_hi, pt;
  logic        locked, done_f, err_f, aerr_f;
  logic        acs_q, spop_q, ds_q;
  logic [2:0]  idx_q;
  logic [5:0]  cnt_q;
  logic        busy;

  logic [2:0]  w_idx;
  logic [1:0]  w_kind, cur_kind;
  logic [31:0] cur_word;
  logic [7:0]  main_op, pre_op;
  logic        go_wr;
  logic        unused_rdata;

  assign go_wr    = wr_en && (wr_sel == 2'd0);
  assign w_idx    = wr_data[14:12];
  assign w_kind   = pt[5'd16 + {w_idx, 1'b0} +: 2];
  assign cur_kind = pt[5'd16 + {idx_q, 1'b0} +: 2];
  assign cur_word = idx_q[2] ? menu_hi : menu_lo;
  assign main_op  = cur_word[{idx_q[1:0], 3'b000} +: 8];
  assign pre_op   = spop_q ? pt[15:8] : pt[7:0];
  assign busy     = (st != ST_IDLE);
  assign sh_valid = busy;
  assign unused_rdata = ^sh_rdata;

  always_comb begin
    sh_opcode   = main_op;
    sh_addr_en  = 1'b0;
    sh_write    = 1'b0;
    sh_data_en  = 1'b0;
    sh_data_cnt = 6'd0;
    case (st)
      ST_PRE: begin
        sh_opcode = pre_op;
        sh_write  = 1'b1;
      end
      ST_MAIN: begin
        sh_opcode   = main_op;
        sh_addr_en  = cur_kind[1];
        sh_write    = cur_kind[0];
        sh_data_en  = ds_q;
        sh_data_cnt = ds_q ? cnt_q : 6'd0;
      end
      ST_POLL: begin
        sh_opcode  = POLL_OP;
        sh_data_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = {9'd0, ds_q, cnt_q, locked, idx_q, spop_q, acs_q,
                          1'b0, 4'd0, aerr_f, err_f, done_f, 1'b0, busy};
      2'd1:    rd_data = pt;
      2'd2:    rd_data = menu_lo;
      default: rd_data = menu_hi;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      menu_lo <= '0;
      menu_hi <= '0;
      pt      <= '0;
      locked  <= 1'b0;
      done_f  <= 1'b0;
      err_f   <= 1'b0;
      aerr_f  <= 1'b0;
      acs_q   <= 1'b0;
      spop_q  <= 1'b0;
      ds_q    <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (lock_req) locked <= 1'b1;

      if (wr_en && !locked) begin
        case (wr_sel)
          2'd1: pt      <= wr_data;
          2'd2: menu_lo <= wr_data;
          2'd3: menu_hi <= wr_data;
          default: ;
        endcase
      end

      if (go_wr) begin
        if (wr_data[2]) done_f <= 1'b0;
        if (wr_data[3]) err_f  <= 1'b0;
        if (wr_data[4]) aerr_f <= 1'b0;
        if (wr_data[9] && !busy) begin
          idx_q  <= w_idx;
          acs_q  <= wr_data[10];
          spop_q <= wr_data[11];
          cnt_q  <= wr_data[21:16];
          ds_q   <= wr_data[22];
          if (wr_data[10] && !w_kind[0]) err_f <= 1'b1;
          else st <= wr_data[10] ? ST_PRE : ST_MAIN;
        end
      end

      if (busy && sh_done) begin
        if (sh_err) begin
          aerr_f <= 1'b1;
          done_f <= 1'b1;
          st     <= ST_IDLE;
        end else begin
          case (st)
            ST_PRE:  st <= ST_MAIN;
            ST_MAIN: begin
              if (acs_q) st <= ST_POLL;
              else begin
                done_f <= 1'b1;
                st     <= ST_IDLE;
              end
            end
            ST_POLL: begin
              if (!sh_rdata[BUSY_BIT]) begin
                done_f <= 1'b1;
                st     <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/flash_swseq_chk.sv
module flash_swseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sh_valid,
  input logic       sh_done,
  input logic [7:0] sh_opcode,
  input logic       busy,
  input logic       locked,
  input logic       done_f
);
  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sh_valid && !sh_done |=> sh_valid && $stable(sh_opcode)); // R6

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sh_valid); // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R9

  AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_f); // R5

  AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> !busy); // R11
endmodule

bind flash_swseq flash_swseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sh_valid(sh_valid), .sh_done(sh_done),
  .sh_opcode(sh_opcode), .busy(busy), .locked(locked), .done_f(done_f)
);

// File: tb/flash_swseq_bench.sv
module flash_swseq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        lock_req = 1'b0;
  logic        sh_valid, sh_addr_en, sh_write, sh_data_en;
  logic [7:0]  sh_opcode;
  logic [5:0]  sh_data_cnt;
  logic        sh_done = 1'b0;
  logic        sh_err = 1'b0;
  logic [7:0]  sh_rdata = '0;

  int tests = 0, fails = 0;
  bit finished = 0;

  flash_swseq u_flash_swseq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .lock_req(lock_req),
    .sh_valid(sh_valid), .sh_opcode(sh_opcode), .sh_addr_en(sh_addr_en),
    .sh_write(sh_write), .sh_data_en(sh_data_en), .sh_data_cnt(sh_data_cnt),
    .sh_done(sh_done), .sh_err(sh_err), .sh_rdata(sh_rdata)
  );

  always #10 clk = ~clk;

  // shifter model and frame log
  logic [16:0] lg [16];
  int nlog = 0, dly = 0, poll_busy = 0, err_at = -1;

  always @(negedge clk) begin
    if (sh_done) begin
      sh_done = 1'b0;
      sh_err  = 1'b0;
      dly     = 0;
    end else if (sh_valid) begin
      if (dly == 2) begin
        sh_done = 1'b1;
        sh_err  = (nlog == err_at);
        if (sh_opcode == 8'h05 && !sh_write) begin
          sh_rdata = (poll_busy > 0) ? 8'h01 : 8'h00;
          if (poll_busy > 0) poll_busy = poll_busy - 1;
        end else sh_rdata = 8'hFE;
        if (nlog < 16)
          lg[nlog] = {sh_opcode, sh_addr_en, sh_write, sh_data_en, sh_data_cnt};
        nlog = nlog + 1;
      end else dly = dly + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [31:0] v);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      rd(2'd0, v);
      if (!v[0]) break;
    end
  endtask

  function automatic logic [31:0] ctl(int idx, int cnt, bit ds, bit acs, bit spop);
    return (32'd1 << 9) | (32'(acs) << 10) | (32'(spop) << 11) |
           (32'(idx) << 12) | (32'(cnt) << 16) | (32'(ds) << 22);
  endfunction

  function automatic logic [16:0] frm(logic [7:0] op, bit a, bit w, bit de, logic [5:0] c);
    return {op, a, w, de, c};
  endfunction

  task automatic start(logic [31:0] w, int pb, int ea);
    nlog = 0; poll_busy = pb; err_at = ea;
    wr(2'd0, w);
  endtask

  task automatic clear_flags();
    wr(2'd0, 32'h1C);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R5 reset status", v, 32'h0);
    chk("R5 reset no frame", {31'd0, sh_valid}, 32'd0);
  endtask

  task automatic t_config();
    logic [31:0] v;
    wr(2'd2, 32'h44332211);
    wr(2'd3, 32'h88776655);
    wr(2'd1, 32'h1BE45006);
    rd(2'd2, v); chk("R1 table low readback", v, 32'h44332211);
    rd(2'd3, v); chk("R1 table high readback", v, 32'h88776655);
    rd(2'd1, v); chk("R2 prefix/kind readback", v, 32'h1BE45006);
  endtask

  task automatic t_plain_read();
    logic [31:0] v;
    start(ctl(2, 3, 1, 0, 0), 0, -1);
    chk("R3 valid after go", {31'd0, sh_valid}, 32'd1);
    rd(2'd0, v); chk("R5 in progress", {31'd0, v[0]}, 32'd1);
    wait_idle();
    chk("R1 frame count", nlog, 1);
    chk("R4 read-with-address frame", {15'd0, lg[0]}, {15'd0, frm(8'h33, 1, 0, 1, 6'd3)});
    rd(2'd0, v); chk("R5 done status", v, 32'h00432004);
    clear_flags();
    rd(2'd0, v); chk("R5 write-one clear", {29'd0, v[4:2]}, 32'd0);
  endtask

  task automatic t_no_data();
    start(ctl(3, 9, 0, 0, 0), 0, -1);
    wait_idle();
    chk("R4 no data phase", {15'd0, lg[0]}, {15'd0, frm(8'h44, 1, 1, 0, 6'd0)});
    clear_flags();
    start(ctl(5, 1, 1, 0, 0), 0, -1);
    wait_idle();
    chk("R1 high table entry", {15'd0, lg[0]}, {15'd0, frm(8'h66, 1, 0, 1, 6'd1)});
    clear_flags();
  endtask

  task automatic t_atomic_lo();
    start(ctl(4, 0, 0, 1, 0), 2, -1);
    wait_idle();
    chk("R7 frame count with polls", nlog, 5);
    chk("R6 prefix A frame", {15'd0, lg[0]}, {15'd0, frm(8'h06, 0, 1, 0, 6'd0)});
    chk("R6 main frame", {15'd0, lg[1]}, {15'd0, frm(8'h55, 1, 1, 0, 6'd0)});
    chk("R7 poll frame", {15'd0, lg[4]}, {15'd0, frm(8'h05, 0, 0, 1, 6'd0)});
    clear_flags();
  endtask

  task automatic t_atomic_hi();
    logic [31:0] v;
    start(ctl(1, 0, 0, 1, 1), 0, -1);
    wait_idle();
    chk("R7 single poll", nlog, 3);
    chk("R6 prefix B frame", {24'd0, lg[0][16:9]}, 32'h50);
    chk("R6 main after prefix B", {24'd0, lg[1][16:9]}, 32'h22);
    rd(2'd0, v); chk("R5 done after poll", {31'd0, v[2]}, 32'd1);
    clear_flags();
  endtask

  task automatic t_atomic_read();
    logic [31:0] v;
    start(ctl(0, 0, 1, 1, 0), 0, -1);
    repeat (5) @(negedge clk);
    rd(2'd0, v);
    chk("R8 error set", {31'd0, v[3]}, 32'd1);
    chk("R8 not in progress", {31'd0, v[0]}, 32'd0);
    chk("R8 no frame", nlog, 0);
    clear_flags();
  endtask

  task automatic t_go_busy();
    logic [31:0] v;
    start(ctl(4, 0, 0, 1, 0), 4, -1);
    wr(2'd0, ctl(2, 5, 1, 0, 0));
    rd(2'd0, v); chk("R10 fields kept", {29'd0, v[14:12]}, 32'd4);
    wait_idle();
    chk("R10 sequence unchanged", nlog, 7);
    chk("R10 main opcode", {24'd0, lg[1][16:9]}, 32'h55);
    clear_flags();
  endtask

  task automatic t_shift_err();
    logic [31:0] v;
    start(ctl(3, 0, 0, 1, 0), 0, 0);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R11 stops after error", nlog, 1);
    rd(2'd0, v); chk("R11 access error status", v, 32'h00003414);
    clear_flags();
  endtask

  task automatic t_lock();
    logic [31:0] v;
    @(negedge clk); lock_req = 1'b1;
    @(negedge clk); lock_req = 1'b0;
    rd(2'd0, v); chk("R9 lock bit", {31'd0, v[15]}, 32'd1);
    wr(2'd2, 32'hDEADBEEF);
    wr(2'd1, 32'h0);
    rd(2'd2, v); chk("R9 table frozen", v, 32'h44332211);
    rd(2'd1, v); chk("R9 prefix/kind frozen", v, 32'h1BE45006);
    start(ctl(0, 0, 1, 0, 0), 0, -1);
    wait_idle();
    chk("R9 command after lock", {15'd0, lg[0]}, {15'd0, frm(8'h11, 0, 0, 1, 6'd0)});
    rd(2'd0, v); chk("R9 lock persists", {31'd0, v[15]}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_config();
    t_plain_read();
    t_no_data();
    t_atomic_lo();
    t_atomic_hi();
    t_atomic_read();
    t_go_busy();
    t_shift_err();
    t_lock();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R5 watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule